// File: doc/BRIEF.md
# Cascadable Eight-Input Interrupt Controller

This block gathers eight interrupt request lines, latches each on its rising edge, and resolves them under a fixed priority into a single request toward the processor. The processor answers with an acknowledge pulse. In that cycle the controller places an 8-bit vector on the data bus and records the granted line in an in-service register. While a line is in service it blocks all requests of equal or lower priority until software issues an end-of-interrupt command. Software programs a mask, a vector base and a cascade setting through a small synchronous register port.

Several controllers can be chained. The configuration input `master_i` selects the role. A master marks some of its inputs as coming from slaves. When the master grants one of those inputs, it does not drive the data bus. It places the input index on a 3-bit cascade bus instead. A slave whose programmed identity matches that index answers the acknowledge with its own vector. A slave's `int_o` is wired to one master input, usually input 2. The acknowledge is a single-cycle, synchronous pulse, and all controllers in the chain see it in the same cycle.

Top module: `irq_hub`

## Requirements
- R1: After reset the request, in-service, mask, vector base and cascade registers are all zero, `int_o` is low, and neither the data bus nor the cascade bus is driven.
- R2: A rising edge on `irq_i[k]` latches request bit k. A line held high latches only once. A latched bit is cleared in the cycle its acknowledge is accepted.
- R3: Priority is fixed, with index 0 highest. `int_o` is high exactly when some latched, unmasked request has a lower index than every in-service bit (or nothing is in service).
- R4: When a master accepts an acknowledge for an input whose cascade bit is clear, `data_oe_o` is high in that same cycle and `data_o` equals vector base bits 7:3 concatenated with the 3-bit winning index.
- R5: An accepted acknowledge sets the winning in-service bit. From the next cycle on, requests of equal or lower priority are held back, and higher ones still raise `int_o`.
- R6: An end-of-interrupt command clears only the lowest-index bit that is set in the in-service register.
- R7: A set mask bit keeps its input from raising `int_o` but does not discard its latched request. Clearing the mask bit presents that request again.
- R8: An acknowledge while `int_o` is low drives no bus and changes no register.
- R9: When a master accepts an acknowledge for an input whose cascade bit is set, `cas_o` carries the index and `cas_valid_o` is high, and `data_oe_o` stays low.
- R10: A slave accepts an acknowledge only when `cas_valid_i` is high, `cas_i` equals its identity, and its `int_o` is high. It then drives its own vector. Otherwise it stays silent and keeps its state. A slave never drives the cascade bus.
- R11: Register port (write with `cfg_we_i`): address 0 is the mask (bit k for input k), address 1 is the vector base (bits 7:3 kept), address 2 is the end-of-interrupt command (data ignored), and address 3 is the cascade setting (master: bit k marks input k as cascaded; slave: bits 2:0 are its identity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 selects the master role, 0 the slave role |
| irq_i | input | 8 | Interrupt request lines, edge sensitive |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| cas_i | input | 3 | Cascade index seen by a slave |
| cas_valid_i | input | 1 | Cascade index valid, seen by a slave |
| int_o | output | 1 | Interrupt request to the processor or to a master input |
| data_o | output | 8 | Vector, zero when not driven |
| data_oe_o | output | 1 | Vector drive enable |
| cas_o | output | 3 | Cascade index driven by a master |
| cas_valid_o | output | 1 | Cascade index valid |

## Verification
The bench runs a real master and slave pair against a behavioural model of both. It first targets preemption. A higher request that arrives while a lower one is in service must raise `int_o` at once, and a lower one must not. A design that compared against the wrong in-service bit, or treated equal priority as higher, would nest interrupts wrongly. Next it targets end-of-interrupt ordering with two nested bits. A design that cleared the wrong bit would release the outer handler early. It also holds a request level high, masks a latched request, and sends acknowledges with nothing pending, which catches level retriggering, lost masked requests, and spurious vectors. Finally, it runs the cascaded path with a matching and a mismatched slave identity. A design that let the master drive data, or let the wrong slave answer, would produce bus contention or no vector.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned NIRQ   = 8;
  localparam int unsigned IDX_W  = $clog2(NIRQ);
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned BASE_W = VEC_W - IDX_W;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MASK = 2'd0,
    REG_BASE = 2'd1,
    REG_EOI  = 2'd2,
    REG_CASC = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_hub_prio.sv
// Lowest set index wins.
module irq_hub_prio #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub_edge.sv
// Rising-edge capture into the request register.
module irq_hub_edge #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] grant_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] rise;

  assign rise = irq_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_o  <= (irr_o & ~grant_i) | rise;
    end
  end
endmodule

// File: rtl/irq_hub_isr.sv
// In-service tracking: grant sets, end-of-interrupt clears the top bit.
module irq_hub_isr #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  grant_i,
  input  logic          eoi_i,
  output logic [N-1:0]  isr_o,
  output logic          busy_o,
  output logic [IW-1:0] top_o
);
  logic [N-1:0] clr;

  irq_hub_prio #(.N(N)) u_top (
    .vec_i (isr_o),
    .any_o (busy_o),
    .idx_o (top_o)
  );

  always_comb begin
    clr = '0;
    if (eoi_i && busy_o) clr[top_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_o <= '0;
    else         isr_o <= (isr_o & ~clr) | grant_i;
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [NIRQ-1:0]   irq_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [VEC_W-1:0]  cfg_wdata_i,
  input  logic              inta_i,
  input  logic [IDX_W-1:0]  cas_i,
  input  logic              cas_valid_i,
  output logic              int_o,
  output logic [VEC_W-1:0]  data_o,
  output logic              data_oe_o,
  output logic [IDX_W-1:0]  cas_o,
  output logic              cas_valid_o
);
  logic [NIRQ-1:0]   irr_q, isr_q, mask_q, casc_q, grant;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  win_idx, top_idx;
  logic              win_any, busy, ack, to_slave, sel_me, eoi;

  irq_hub_edge #(.N(NIRQ)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_i   (irq_i),
    .grant_i (grant),
    .irr_o   (irr_q)
  );

  irq_hub_prio #(.N(NIRQ)) u_win (
    .vec_i (irr_q & ~mask_q),
    .any_o (win_any),
    .idx_o (win_idx)
  );

  irq_hub_isr #(.N(NIRQ)) u_isr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .grant_i (grant),
    .eoi_i   (eoi),
    .isr_o   (isr_q),
    .busy_o  (busy),
    .top_o   (top_idx)
  );

  assign int_o  = win_any && (!busy || (win_idx < top_idx));
  assign sel_me = master_i || (cas_valid_i && (cas_i == casc_q[IDX_W-1:0]));
  assign ack    = inta_i && int_o && sel_me;
  assign to_slave = master_i && casc_q[win_idx];
  assign eoi    = cfg_we_i && (cfg_addr_i == REG_EOI);

  always_comb begin
    grant = '0;
    if (ack) grant[win_idx] = 1'b1;
  end

  assign data_oe_o   = ack && !to_slave;
  assign data_o      = data_oe_o ? {base_q, win_idx} : '0;
  assign cas_valid_o = ack && to_slave;
  assign cas_o       = cas_valid_o ? win_idx : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
      casc_q <= '0;
    end else if (cfg_we_i) begin
      unique case (reg_addr_e'(cfg_addr_i))
        REG_MASK: mask_q <= cfg_wdata_i;
        REG_BASE: base_q <= cfg_wdata_i[VEC_W-1:IDX_W];
        REG_CASC: casc_q <= cfg_wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              inta_i,
  input logic              cfg_we_i,
  input logic [ADDR_W-1:0] cfg_addr_i,
  input logic              int_o,
  input logic [VEC_W-1:0]  data_o,
  input logic              data_oe_o,
  input logic              cas_valid_o,
  input logic [NIRQ-1:0]   irr_i,
  input logic [NIRQ-1:0]   isr_i
);
  p_int_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (irr_i != '0));

  p_drive_in_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (inta_i && int_o));

  p_ack_marks_isr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |=> isr_i[$past(data_o[IDX_W-1:0])]);

  p_eoi_one_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == REG_EOI && !inta_i && isr_i != '0)
      |=> ($countones(isr_i) + 1 == $countones($past(isr_i))));

  p_no_ack_no_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o && !cfg_we_i) |=> $stable(isr_i));

  p_bus_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_oe_o && cas_valid_o));

  p_slave_no_cas_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !cas_valid_o);
endmodule

bind irq_hub irq_hub_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .master_i    (master_i),
  .inta_i      (inta_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_addr_i  (cfg_addr_i),
  .int_o       (int_o),
  .data_o      (data_o),
  .data_oe_o   (data_oe_o),
  .cas_valid_o (cas_valid_o),
  .irr_i       (irr_q),
  .isr_i       (isr_q)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] irq_m = '0, irq_s = '0;
  logic       inta = 1'b0;
  logic       we_m = 1'b0, we_s = 1'b0;
  logic [1:0] ad_m = '0, ad_s = '0;
  logic [7:0] wd_m = '0, wd_s = '0;

  logic       m_int, s_int, m_oe, s_oe, m_cv, s_cv;
  logic [7:0] m_data, s_data;
  logic [2:0] m_cas, s_cas;
  logic [7:0] m_irq_in;
  assign m_irq_in = {irq_m[7:3], s_int, irq_m[1:0]};

  irq_hub uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1), .irq_i(m_irq_in),
    .cfg_we_i(we_m), .cfg_addr_i(ad_m), .cfg_wdata_i(wd_m), .inta_i(inta),
    .cas_i(3'd0), .cas_valid_i(1'b0), .int_o(m_int), .data_o(m_data),
    .data_oe_o(m_oe), .cas_o(m_cas), .cas_valid_o(m_cv)
  );

  irq_hub u_slave (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0), .irq_i(irq_s),
    .cfg_we_i(we_s), .cfg_addr_i(ad_s), .cfg_wdata_i(wd_s), .inta_i(inta),
    .cas_i(m_cas), .cas_valid_i(m_cv), .int_o(s_int), .data_o(s_data),
    .data_oe_o(s_oe), .cas_o(s_cas), .cas_valid_o(s_cv)
  );

  wire       bus_oe = m_oe | s_oe;
  wire [7:0] bus    = m_oe ? m_data : s_data;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural model, index 0 master, 1 slave
  logic [7:0] r_irr[2], r_isr[2], r_mask[2], r_casc[2], r_prev[2];
  logic [4:0] r_base[2];
  int         e_win[2];
  bit         e_int[2], e_ack[2];
  bit         e_moe, e_soe, e_cv;
  logic [7:0] e_mdata, e_sdata;
  logic [2:0] e_cas;

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      r_irr[k] = '0; r_isr[k] = '0; r_mask[k] = '0;
      r_casc[k] = '0; r_prev[k] = '0; r_base[k] = '0;
    end
  endtask

  task automatic model_eval();
    for (int k = 0; k < 2; k++) begin
      e_win[k] = lowest(r_irr[k] & ~r_mask[k]);
      e_int[k] = (e_win[k] < 8) && (e_win[k] < lowest(r_isr[k]));
    end
    e_ack[0] = inta && e_int[0];
    e_cv  = e_ack[0] && r_casc[0][e_win[0] % 8];
    e_moe = e_ack[0] && !e_cv;
    e_mdata = e_moe ? {r_base[0], 3'(e_win[0])} : 8'h00;
    e_cas = e_cv ? 3'(e_win[0]) : 3'd0;
    e_ack[1] = inta && e_int[1] && e_cv && (e_cas == r_casc[1][2:0]);
    e_soe = e_ack[1];
    e_sdata = e_soe ? {r_base[1], 3'(e_win[1])} : 8'h00;
  endtask

  task automatic model_update();
    logic [7:0] in_v[2];
    bit         we[2];
    logic [1:0] ad[2];
    logic [7:0] wd[2];
    in_v[0] = {irq_m[7:3], e_int[1], irq_m[1:0]};
    in_v[1] = irq_s;
    we[0] = we_m; ad[0] = ad_m; wd[0] = wd_m;
    we[1] = we_s; ad[1] = ad_s; wd[1] = wd_s;
    for (int k = 0; k < 2; k++) begin
      logic [7:0] g, c;
      int t;
      g = '0; c = '0;
      if (e_ack[k]) g[e_win[k]] = 1'b1;
      t = lowest(r_isr[k]);
      if (we[k] && ad[k] == 2'd2 && t < 8) c[t] = 1'b1;
      r_irr[k] = (r_irr[k] & ~g) | (in_v[k] & ~r_prev[k]);
      r_prev[k] = in_v[k];
      r_isr[k] = (r_isr[k] & ~c) | g;
      if (we[k]) begin
        if (ad[k] == 2'd0) r_mask[k] = wd[k];
        if (ad[k] == 2'd1) r_base[k] = wd[k][7:3];
        if (ad[k] == 2'd3) r_casc[k] = wd[k];
      end
    end
  endtask

  // compare, then advance one clock; called right after a negedge
  task automatic cycle();
    #1;
    model_eval();
    chk("R3 master int_o", m_int, e_int[0]);
    chk("R10 slave int_o", s_int, e_int[1]);
    chk("R4 master data_oe_o", m_oe, e_moe);
    chk("R4 master data_o", m_data, e_mdata);
    chk("R9 master cas_valid_o", m_cv, e_cv);
    chk("R9 master cas_o", m_cas, e_cas);
    chk("R10 slave data_oe_o", s_oe, e_soe);
    chk("R10 slave data_o", s_data, e_sdata);
    chk("R10 slave cas_valid_o", s_cv, 1'b0);
    @(posedge clk);
    if (rst_n) model_update(); else model_reset();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(bit slv, logic [1:0] a, logic [7:0] d);
    if (slv) begin we_s = 1'b1; ad_s = a; wd_s = d; end
    else     begin we_m = 1'b1; ad_m = a; wd_m = d; end
    cycle();
    we_s = 1'b0; we_m = 1'b0;
  endtask

  task automatic pulse_m(int b);
    irq_m[b] = 1'b1; cycle(); irq_m[b] = 1'b0; cycle();
  endtask

  task automatic pulse_s(int b);
    irq_s[b] = 1'b1; cycle(); irq_s[b] = 1'b0; cycle();
  endtask

  // acknowledge cycle with a direct expectation on the shared bus
  task automatic ack_expect(string tag, bit exp_oe, logic [7:0] exp_d);
    inta = 1'b1;
    #1;
    chk(tag, bus_oe, exp_oe);
    if (exp_oe) chk(tag, bus, exp_d);
    cycle();
    inta = 1'b0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    idle(3);
    rst_n = 1'b1;
    #1;
    chk("R1 int_o after reset", {m_int, s_int}, 2'b00);
    chk("R1 no drive after reset", {m_oe, s_oe, m_cv}, 3'b000);
    @(negedge clk);

    // R11 programming
    wr(0, 2'd1, 8'h40);
    wr(0, 2'd3, 8'h04);
    wr(1, 2'd1, 8'h70);
    wr(1, 2'd3, 8'h02);
    idle(1);

    // R4, R5 nesting and preemption
    pulse_m(5);
    chk("R3 int_o for IR5", m_int, 1'b1);
    ack_expect("R4 vector IR5", 1'b1, 8'h45);
    pulse_m(6);
    chk("R5 lower blocked", m_int, 1'b0);
    pulse_m(3);
    chk("R5 higher preempts", m_int, 1'b1);
    ack_expect("R4 vector IR3", 1'b1, 8'h43);
    wr(0, 2'd2, 8'h00);
    chk("R6 EOI cleared IR3 only, IR6 still blocked", m_int, 1'b0);
    wr(0, 2'd2, 8'h00);
    chk("R6 EOI cleared IR5, IR6 presented", m_int, 1'b1);
    ack_expect("R4 vector IR6", 1'b1, 8'h46);
    wr(0, 2'd2, 8'h00);

    // R2 held level latches once
    irq_m[1] = 1'b1;
    idle(2);
    ack_expect("R2 vector IR1", 1'b1, 8'h41);
    idle(2);
    wr(0, 2'd2, 8'h00);
    idle(2);
    chk("R2 held level no relatch", m_int, 1'b0);
    irq_m[1] = 1'b0;
    idle(1);

    // R3 simultaneous edges
    irq_m[4] = 1'b1; irq_m[7] = 1'b1; cycle();
    irq_m[4] = 1'b0; irq_m[7] = 1'b0; cycle();
    ack_expect("R3 IR4 beats IR7", 1'b1, 8'h44);
    wr(0, 2'd2, 8'h00);
    ack_expect("R3 IR7 next", 1'b1, 8'h47);
    wr(0, 2'd2, 8'h00);

    // R7 mask keeps latched request
    wr(0, 2'd0, 8'h01);
    pulse_m(0);
    chk("R7 masked IR0 silent", m_int, 1'b0);
    idle(2);
    wr(0, 2'd0, 8'h00);
    chk("R7 unmasked IR0 presented", m_int, 1'b1);
    ack_expect("R7 vector IR0", 1'b1, 8'h40);
    wr(0, 2'd2, 8'h00);

    // R8 acknowledge with nothing pending
    ack_expect("R8 spurious acknowledge", 1'b0, 8'h00);
    chk("R8 no state change", m_int, 1'b0);
    idle(1);

    // R9, R10 cascaded path
    pulse_s(6);
    idle(2);
    chk("R9 master sees slave request", m_int, 1'b1);
    inta = 1'b1;
    #1;
    chk("R9 cascade index", {m_cv, m_cas}, {1'b1, 3'd2});
    chk("R9 master silent on data", m_oe, 1'b0);
    chk("R10 slave vector", {s_oe, s_data}, {1'b1, 8'h76});
    cycle();
    inta = 1'b0;
    wr(1, 2'd2, 8'h00);
    wr(0, 2'd2, 8'h00);
    idle(2);

    // R10 local request while slave pending: master answers, slave silent
    pulse_s(5);
    irq_m[0] = 1'b1; cycle(); irq_m[0] = 1'b0;
    idle(2);
    inta = 1'b1;
    #1;
    chk("R10 slave silent for master IR0", s_oe, 1'b0);
    chk("R4 master IR0 vector", {m_oe, m_data}, {1'b1, 8'h40});
    cycle();
    inta = 1'b0;
    wr(0, 2'd2, 8'h00);
    // R10 identity mismatch: nobody drives data
    wr(1, 2'd3, 8'h05);
    idle(1);
    inta = 1'b1;
    #1;
    chk("R10 cascade index issued", m_cv, 1'b1);
    chk("R10 mismatched slave silent", bus_oe, 1'b0);
    cycle();
    inta = 1'b0;
    chk("R10 slave keeps request", s_int, 1'b1);
    idle(2);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule